// File: doc/BRIEF.md
# Two-Accumulator Fixed-Point ALU with Condition Codes

This block is the arithmetic core of a small accumulator machine. It holds two 16-bit signed accumulators, the primary `acc1` and the secondary `acc2`. A load pushes the primary value down into the secondary before the new value is written. Add and subtract write their result to the primary. Six signed compares set a logic result bit. A swap exchanges the two accumulators, and a byte step adds or subtracts an 8-bit immediate in the low byte of the primary only.

Every result-producing operation leaves a two-bit sign code (`cc1`,`cc0`) and an overflow flag. Five jump opcodes test these flags and raise `jmp_taken` for one cycle. The sequencer that owns the program counter acts on that bit. All outputs are registered and update on the clock edge that samples the opcode.

Top module: `fxalu_cc`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears both accumulators, `cc1`, `cc0`, `ov`, `rlo` and `jmp_taken` to 0, whatever the opcode.
- R2: Opcode 5'h01 (load) sets `acc2` to the old `acc1` and `acc1` to `ld_data`, and leaves the flags and `rlo` unchanged.
- R3: Opcode 5'h02 (add) writes `acc1 + acc2`, wrapped to 16 bits, into `acc1` and leaves `acc2` unchanged. It sets `ov` exactly when the true signed sum lies outside -32768..+32767.
- R4: Opcode 5'h03 (subtract) writes `acc2 - acc1`, wrapped to 16 bits, into `acc1` and leaves `acc2` unchanged. It sets `ov` exactly when the true signed difference is out of range.
- R5: After add or subtract, {`cc1`,`cc0`} reflects the stored 16-bit result: 2'b10 when it is greater than zero, 2'b01 when it is less than zero, and 2'b00 when it is zero. The pair is never 2'b11.
- R6: The compares test `acc2` against `acc1` as signed numbers: 5'h08 equal, 5'h09 not equal, 5'h0A greater, 5'h0B greater-or-equal, 5'h0C less, 5'h0D less-or-equal. Each sets `rlo` to the test's outcome and sets {`cc1`,`cc0`} to 2'b10 when `acc2` > `acc1`, 2'b01 when it is less and 2'b00 when they are equal. The accumulators and `ov` do not change.
- R7: Opcode 5'h04 (swap) exchanges `acc1` and `acc2` and leaves the flags and `rlo` unchanged.
- R8: Opcode 5'h05 adds and 5'h06 subtracts `imm_n` in `acc1[7:0]` modulo 256. `acc1[15:8]`, `acc2`, the flags and `rlo` stay unchanged.
- R9: The jump opcodes set `jmp_taken` in the following cycle as follows: 5'h10 when {`cc1`,`cc0`}=2'b10, 5'h11 when it is 2'b01, 5'h12 when it is 2'b00, 5'h13 when it is not 2'b00, and 5'h14 when `ov`=1. Every other opcode leaves `jmp_taken` at 0.
- R10: Jump opcodes, 5'h00 (no operation) and undefined codes leave the accumulators, `cc1`, `cc0`, `ov` and `rlo` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op | input | 5 | Opcode, sampled every clock |
| ld_data | input | 16 | Value written to `acc1` by a load |
| imm_n | input | 8 | Immediate for the low-byte step |
| acc1 | output | 16 | Primary accumulator |
| acc2 | output | 16 | Secondary accumulator |
| cc1 | output | 1 | Condition code, upper bit |
| cc0 | output | 1 | Condition code, lower bit |
| ov | output | 1 | Signed overflow of the last add or subtract |
| rlo | output | 1 | Logic result of the last compare |
| jmp_taken | output | 1 | Predicate of the jump opcode sampled at the last edge |

## Verification
Every result is due exactly one clock edge after the opcode is sampled. This covers the accumulators, both condition codes, `ov`, `rlo` and `jmp_taken`, and no path spans more cycles. The bench drives each opcode at a falling edge, lets one rising edge pass, and reads all outputs at the next falling edge. That places each check in the single cycle in which the result first appears. A jump is followed by a non-jump opcode, so the bench also sees `jmp_taken` drop back to 0 one edge later.

// File: rtl/fxalu_pkg.sv
// Package fxalu_pkg: opcode encoding shared by the ALU, its submodules and
// its checker. Assumes a 5-bit opcode field; codes not listed act as no-op.
package fxalu_pkg;

    localparam int OP_W = 5;

    typedef enum logic [OP_W-1:0] {
        OP_NOP  = 5'h00,
        OP_LOAD = 5'h01,
        OP_ADD  = 5'h02,
        OP_SUB  = 5'h03,
        OP_SWAP = 5'h04,
        OP_INCB = 5'h05,
        OP_DECB = 5'h06,
        OP_CEQ  = 5'h08,
        OP_CNE  = 5'h09,
        OP_CGT  = 5'h0A,
        OP_CGE  = 5'h0B,
        OP_CLT  = 5'h0C,
        OP_CLE  = 5'h0D,
        OP_JPOS = 5'h10,
        OP_JNEG = 5'h11,
        OP_JZER = 5'h12,
        OP_JNZR = 5'h13,
        OP_JOVF = 5'h14
    } op_e;

    // Sign code of a two-bit condition pair.
    localparam logic [1:0] CC_ZERO = 2'b00;
    localparam logic [1:0] CC_NEG  = 2'b01;
    localparam logic [1:0] CC_POS  = 2'b10;

endpackage

// File: rtl/fxalu_addsub.sv
// Module fxalu_addsub: one shared adder for add (a1 + a2) and subtract
// (a2 - a1). It returns the wrapped result, the signed overflow and the
// sign code of the result. It is purely combinational and assumes
// two's-complement operands of DATA_W bits.
module fxalu_addsub
    import fxalu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              sub,
    input  logic [DATA_W-1:0] a1,
    input  logic [DATA_W-1:0] a2,
    output logic [DATA_W-1:0] res,
    output logic              ovf,
    output logic [1:0]        cc
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] opx;
    logic [DATA_W-1:0] opy;

    // Operand steering: the subtract turns into a2 + ~a1 + 1.
    always_comb begin
        opx = a2;
        opy = sub ? ~a1 : a1;
        res = opx + opy + {{(DATA_W-1){1'b0}}, sub};
    end

    // Overflow: the inputs to the adder agree in sign but the sum does not.
    always_comb begin
        ovf = (opx[MSB] == opy[MSB]) && (res[MSB] != opx[MSB]);
    end

    // Sign code of the stored result.
    always_comb begin
        if (res == '0)     cc = CC_ZERO;
        else if (res[MSB]) cc = CC_NEG;
        else               cc = CC_POS;
    end
endmodule

// File: rtl/fxalu_cmp.sv
// Module fxalu_cmp: signed compare of a2 against a1. It produces the logic
// result selected by the compare opcode and the sign code of (a2 vs a1).
// It is combinational. For a non-compare opcode, hit is 0 and unused.
module fxalu_cmp
    import fxalu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  op_e               opc,
    input  logic [DATA_W-1:0] a1,
    input  logic [DATA_W-1:0] a2,
    output logic              hit,
    output logic [1:0]        cc
);
    logic gt;
    logic lt;
    logic eq;

    // Relation of the two signed operands.
    always_comb begin
        gt = $signed(a2) > $signed(a1);
        lt = $signed(a2) < $signed(a1);
        eq = (a2 == a1);
    end

    // Outcome selected by the compare opcode.
    always_comb begin
        case (opc)
            OP_CEQ:  hit = eq;
            OP_CNE:  hit = !eq;
            OP_CGT:  hit = gt;
            OP_CGE:  hit = gt || eq;
            OP_CLT:  hit = lt;
            OP_CLE:  hit = lt || eq;
            default: hit = 1'b0;
        endcase
    end

    // Sign code of the relation.
    always_comb begin
        if (gt)      cc = CC_POS;
        else if (lt) cc = CC_NEG;
        else         cc = CC_ZERO;
    end
endmodule

// File: rtl/fxalu_bytestep.sv
// Module fxalu_bytestep: adds or subtracts an immediate in the low BYTE_W
// bits of a word, modulo 2**BYTE_W, and passes the upper bits through.
// It is combinational and assumes BYTE_W < DATA_W.
module fxalu_bytestep #(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic              dec,
    input  logic [DATA_W-1:0] a,
    input  logic [BYTE_W-1:0] n,
    output logic [DATA_W-1:0] y
);
    logic [BYTE_W-1:0] lo;

    // Low-byte step, with no carry into the upper bits.
    always_comb begin
        lo = dec ? (a[BYTE_W-1:0] - n) : (a[BYTE_W-1:0] + n);
        y  = {a[DATA_W-1:BYTE_W], lo};
    end
endmodule

// File: rtl/fxalu_jump.sv
// Module fxalu_jump: evaluates the jump predicate named by the opcode from
// the current condition codes and overflow. It is combinational and
// returns 0 for any non-jump opcode.
module fxalu_jump
    import fxalu_pkg::*;
(
    input  op_e        opc,
    input  logic [1:0] cc,
    input  logic       ovf,
    output logic       take
);
    // Predicate table.
    always_comb begin
        case (opc)
            OP_JPOS: take = (cc == CC_POS);
            OP_JNEG: take = (cc == CC_NEG);
            OP_JZER: take = (cc == CC_ZERO);
            OP_JNZR: take = (cc != CC_ZERO);
            OP_JOVF: take = ovf;
            default: take = 1'b0;
        endcase
    end
endmodule

// File: rtl/fxalu_cc.sv
// Module fxalu_cc: two-accumulator signed ALU. It holds acc1 and acc2, the
// condition pair, overflow, the compare result and the jump predicate.
// All state is registered with a synchronous active-low reset, and each
// opcode takes effect at the edge that samples it. The sequencer is
// assumed to act on jmp_taken and to supply ld_data for loads.
module fxalu_cc
    import fxalu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   op,
    input  logic [DATA_W-1:0] ld_data,
    input  logic [BYTE_W-1:0] imm_n,
    output logic [DATA_W-1:0] acc1,
    output logic [DATA_W-1:0] acc2,
    output logic              cc1,
    output logic              cc0,
    output logic              ov,
    output logic              rlo,
    output logic              jmp_taken
);
    op_e               opc;
    logic [DATA_W-1:0] as_res;
    logic              as_ovf;
    logic [1:0]        as_cc;
    logic              cmp_hit;
    logic [1:0]        cmp_cc;
    logic [DATA_W-1:0] step_res;
    logic              jmp_pred;

    logic [DATA_W-1:0] acc1_d;
    logic [DATA_W-1:0] acc2_d;
    logic [1:0]        cc_d;
    logic              ov_d;
    logic              rlo_d;

    // Opcode decode to the enumerated type.
    always_comb opc = op_e'(op);

    fxalu_addsub #(.DATA_W(DATA_W)) u_addsub (
        .sub (opc == OP_SUB),
        .a1  (acc1),
        .a2  (acc2),
        .res (as_res),
        .ovf (as_ovf),
        .cc  (as_cc)
    );

    fxalu_cmp #(.DATA_W(DATA_W)) u_cmp (
        .opc (opc),
        .a1  (acc1),
        .a2  (acc2),
        .hit (cmp_hit),
        .cc  (cmp_cc)
    );

    fxalu_bytestep #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_step (
        .dec (opc == OP_DECB),
        .a   (acc1),
        .n   (imm_n),
        .y   (step_res)
    );

    fxalu_jump u_jump (
        .opc  (opc),
        .cc   ({cc1, cc0}),
        .ovf  (ov),
        .take (jmp_pred)
    );

    // Next-state selection: every field holds unless the opcode writes it.
    always_comb begin
        acc1_d = acc1;
        acc2_d = acc2;
        cc_d   = {cc1, cc0};
        ov_d   = ov;
        rlo_d  = rlo;
        case (opc)
            OP_LOAD: begin
                acc2_d = acc1;
                acc1_d = ld_data;
            end
            OP_ADD, OP_SUB: begin
                acc1_d = as_res;
                ov_d   = as_ovf;
                cc_d   = as_cc;
            end
            OP_SWAP: begin
                acc1_d = acc2;
                acc2_d = acc1;
            end
            OP_INCB, OP_DECB: acc1_d = step_res;
            OP_CEQ, OP_CNE, OP_CGT, OP_CGE, OP_CLT, OP_CLE: begin
                rlo_d = cmp_hit;
                cc_d  = cmp_cc;
            end
            default: ;
        endcase
    end

    // State registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc1      <= '0;
            acc2      <= '0;
            cc1       <= 1'b0;
            cc0       <= 1'b0;
            ov        <= 1'b0;
            rlo       <= 1'b0;
            jmp_taken <= 1'b0;
        end else begin
            acc1      <= acc1_d;
            acc2      <= acc2_d;
            {cc1, cc0} <= cc_d;
            ov        <= ov_d;
            rlo       <= rlo_d;
            jmp_taken <= jmp_pred;
        end
    end
endmodule

// File: rtl/fxalu_cc_chk.sv
// Module fxalu_cc_chk: temporal properties of fxalu_cc, observed at its
// ports and bound to every instance of it.
module fxalu_cc_chk
    import fxalu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [OP_W-1:0]   op,
    input logic [DATA_W-1:0] ld_data,
    input logic [DATA_W-1:0] acc1,
    input logic [DATA_W-1:0] acc2,
    input logic              cc1,
    input logic              cc0,
    input logic              ov,
    input logic              rlo,
    input logic              jmp_taken
);
    localparam int MSB = DATA_W - 1;

    logic is_jump;
    logic is_step;
    always_comb begin
        is_jump = (op >= OP_JPOS) && (op <= OP_JOVF);
        is_step = (op == OP_INCB) || (op == OP_DECB);
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (acc1 == '0 && acc2 == '0 && !ov && !rlo && !jmp_taken)); // R1
    AST_LOAD_PUSH: assert property (@(posedge clk) disable iff (!rst_n) op == OP_LOAD |=> (acc2 == $past(acc1) && acc1 == $past(ld_data))); // R2
    AST_ADD_MIXED_SIGN_NO_OV: assert property (@(posedge clk) disable iff (!rst_n) (op == OP_ADD && acc1[MSB] != acc2[MSB]) |=> !ov); // R3
    AST_SUB_KEEPS_ACC2: assert property (@(posedge clk) disable iff (!rst_n) op == OP_SUB |=> $stable(acc2)); // R4
    AST_CC_NEVER_BOTH: assert property (@(posedge clk) disable iff (!rst_n) !(cc1 && cc0)); // R5
    AST_CMP_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n) (op >= OP_CEQ && op <= OP_CLE) |=> ($stable(acc1) && $stable(acc2) && $stable(ov))); // R6
    AST_CMP_EQ_RESULT: assert property (@(posedge clk) disable iff (!rst_n) op == OP_CEQ |=> (rlo == ($past(acc1) == $past(acc2)))); // R6
    AST_SWAP_EXCHANGE: assert property (@(posedge clk) disable iff (!rst_n) op == OP_SWAP |=> (acc1 == $past(acc2) && acc2 == $past(acc1))); // R7
    AST_STEP_HIGH_KEPT: assert property (@(posedge clk) disable iff (!rst_n) is_step |=> ($stable(acc1[MSB:8]) && $stable(acc2) && $stable(ov) && $stable(rlo) && $stable(cc1) && $stable(cc0))); // R8
    AST_NO_JUMP_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n) !is_jump |=> !jmp_taken); // R9
    AST_JUMP_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n) is_jump |=> ($stable(acc1) && $stable(acc2) && $stable(rlo) && $stable(ov) && $stable(cc1) && $stable(cc0))); // R10
endmodule

bind fxalu_cc fxalu_cc_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op        (op),
    .ld_data   (ld_data),
    .acc1      (acc1),
    .acc2      (acc2),
    .cc1       (cc1),
    .cc0       (cc0),
    .ov        (ov),
    .rlo       (rlo),
    .jmp_taken (jmp_taken)
);

// File: tb/fxalu_cc_tb.sv
// Directed bench for fxalu_cc. Inputs change at falling edges and outputs
// are read at the falling edge after the rising edge that applies them.
module fxalu_cc_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  op = 5'h00;
    logic [15:0] ld_data = '0;
    logic [7:0]  imm_n = '0;
    logic [15:0] acc1;
    logic [15:0] acc2;
    logic        cc1;
    logic        cc0;
    logic        ov;
    logic        rlo;
    logic        jmp_taken;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fxalu_cc u_dut (
        .clk(clk), .rst_n(rst_n), .op(op), .ld_data(ld_data), .imm_n(imm_n),
        .acc1(acc1), .acc2(acc2), .cc1(cc1), .cc0(cc0), .ov(ov), .rlo(rlo),
        .jmp_taken(jmp_taken)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Apply one opcode and return at the falling edge after it took effect.
    task automatic step(input logic [4:0] o, input logic [15:0] d, input logic [7:0] n);
        op = o; ld_data = d; imm_n = n;
        @(posedge clk);
        @(negedge clk);
        op = 5'h00;
    endtask

    task automatic load2(input logic [15:0] second, input logic [15:0] first);
        step(5'h01, second, 8'h00);
        step(5'h01, first, 8'h00);
    endtask

    task automatic t_reset();
        op = 5'h01; ld_data = 16'hBEEF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 acc1", acc1, 0); chk("R1 acc2", acc2, 0);
        chk("R1 flags", {cc1, cc0, ov, rlo, jmp_taken}, 0);
        op = 5'h00; rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_load();
        step(5'h01, 16'h1234, 0);
        chk("R2 acc1 first", acc1, 16'h1234);
        chk("R2 acc2 first", acc2, 16'h0000);
        step(5'h01, 16'hABCD, 0);
        chk("R2 acc1", acc1, 16'hABCD); chk("R2 acc2", acc2, 16'h1234);
        chk("R2 flags", {cc1, cc0, ov, rlo}, 0);
    endtask

    task automatic t_add();
        load2(16'h0005, 16'h0007); step(5'h02, 0, 0);
        chk("R3 sum", acc1, 16'h000C); chk("R3 acc2", acc2, 16'h0005);
        chk("R3 ov", ov, 0); chk("R5 pos", {cc1, cc0}, 2'b10);
        load2(16'h7FFF, 16'h0001); step(5'h02, 0, 0);
        chk("R3 wrap", acc1, 16'h8000); chk("R3 ov set", ov, 1);
        chk("R5 neg", {cc1, cc0}, 2'b01);
        load2(16'h0005, 16'hFFFB); step(5'h02, 0, 0);
        chk("R3 zero", acc1, 16'h0000); chk("R3 ov clr", ov, 0);
        chk("R5 zero", {cc1, cc0}, 2'b00);
    endtask

    task automatic t_sub();
        load2(16'h000A, 16'h0003); step(5'h03, 0, 0);
        chk("R4 diff", acc1, 16'h0007); chk("R4 acc2", acc2, 16'h000A);
        chk("R4 ov", ov, 0); chk("R5 sub pos", {cc1, cc0}, 2'b10);
        load2(16'h8000, 16'h0001); step(5'h03, 0, 0);
        chk("R4 wrap", acc1, 16'h7FFF); chk("R4 ov set", ov, 1);
        load2(16'h0003, 16'h000A); step(5'h03, 0, 0);
        chk("R4 neg", acc1, 16'hFFF9); chk("R4 ov clr", ov, 0);
        chk("R5 sub neg", {cc1, cc0}, 2'b01);
    endtask

    task automatic t_cmp();
        load2(16'h7FFF, 16'h0001); step(5'h02, 0, 0);   // ov = 1
        load2(16'hFFFD, 16'h0004);                       // acc2=-3, acc1=4
        step(5'h0A, 0, 0); chk("R6 gt", rlo, 0); chk("R6 cc lt", {cc1, cc0}, 2'b01);
        chk("R6 ov kept", ov, 1);
        step(5'h0C, 0, 0); chk("R6 lt", rlo, 1);
        step(5'h0D, 0, 0); chk("R6 le", rlo, 1);
        step(5'h0B, 0, 0); chk("R6 ge", rlo, 0);
        step(5'h08, 0, 0); chk("R6 eq", rlo, 0);
        step(5'h09, 0, 0); chk("R6 ne", rlo, 1);
        chk("R6 accs", {acc1, acc2}, {16'h0004, 16'hFFFD});
        step(5'h01, 16'h0004, 0);
        step(5'h08, 0, 0); chk("R6 eq same", rlo, 1); chk("R6 cc eq", {cc1, cc0}, 2'b00);
        step(5'h0B, 0, 0); chk("R6 ge same", rlo, 1);
        step(5'h0A, 0, 0); chk("R6 gt same", rlo, 0);
        load2(16'h0009, 16'h0002);
        step(5'h0A, 0, 0); chk("R6 gt pos", rlo, 1); chk("R6 cc gt", {cc1, cc0}, 2'b10);
    endtask

    task automatic t_swap();
        load2(16'h1111, 16'h2222);
        step(5'h04, 0, 0);
        chk("R7 acc1", acc1, 16'h1111); chk("R7 acc2", acc2, 16'h2222);
        chk("R7 flags", {cc1, cc0, rlo}, 3'b101);
    endtask

    task automatic t_byte();
        load2(16'h0001, 16'h0001); step(5'h02, 0, 0);    // cc=10, ov=0, rlo stays 1
        step(5'h01, 16'h12FE, 0);
        step(5'h05, 0, 8'h05); chk("R8 inc wrap", acc1, 16'h1203);
        step(5'h06, 0, 8'h10); chk("R8 dec wrap", acc1, 16'h12F3);
        step(5'h06, 0, 8'h00); chk("R8 dec zero", acc1, 16'h12F3);
        step(5'h05, 0, 8'hFF); chk("R8 inc ff", acc1, 16'h12F2);
        chk("R8 acc2", acc2, 16'h0002);
        chk("R8 flags", {cc1, cc0, ov, rlo}, 4'b1001);
    endtask

    task automatic t_jump();
        // Current state: cc=10, ov=0, rlo=1, acc1=12F2, acc2=0002.
        step(5'h10, 0, 0); chk("R9 jpos", jmp_taken, 1);
        step(5'h11, 0, 0); chk("R9 jneg", jmp_taken, 0);
        step(5'h12, 0, 0); chk("R9 jzer", jmp_taken, 0);
        step(5'h13, 0, 0); chk("R9 jnzr", jmp_taken, 1);
        step(5'h14, 0, 0); chk("R9 jovf clr", jmp_taken, 0);
        step(5'h10, 0, 0);
        chk("R10 jump keeps", {acc1, acc2, cc1, cc0, ov, rlo}, {16'h12F2, 16'h0002, 4'b1001});
        step(5'h00, 0, 0); chk("R9 drop", jmp_taken, 0);
        step(5'h1F, 0, 0);
        chk("R10 undef keeps", {acc1, acc2, cc1, cc0, ov, rlo}, {16'h12F2, 16'h0002, 4'b1001});
        load2(16'h7FFF, 16'h0001); step(5'h02, 0, 0);
        step(5'h11, 0, 0); chk("R9 jneg set", jmp_taken, 1);
        step(5'h14, 0, 0); chk("R9 jovf set", jmp_taken, 1);
        step(5'h10, 0, 0); chk("R9 jpos clr", jmp_taken, 0);
        load2(16'h0003, 16'h0003); step(5'h08, 0, 0);
        step(5'h12, 0, 0); chk("R9 jzer set", jmp_taken, 1);
        step(5'h13, 0, 0); chk("R9 jnzr clr", jmp_taken, 0);
        step(5'h02, 0, 0); chk("R9 nonjump", jmp_taken, 0);
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        @(negedge clk);
        t_reset();
        t_load();
        t_add();
        t_sub();
        t_cmp();
        t_swap();
        t_byte();
        t_jump();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule